// File: doc/BRIEF.md
# Two-Road Traffic Signal Controller with Parade Hold

This block drives the lamps of a crossing where road A meets road B. It is built as two small state machines that talk to each other. A mode machine watches a parade request and a release request and keeps a single mode flag. A lights machine steps the two roads through green, yellow and red. It uses the vehicle sensor on each road and that mode flag to decide when to move.

While the parade flag is set, road B stays green even when its sensor shows no traffic. This keeps a procession moving along road B. The lights machine moves only on cycles where the step enable is high, so a slower timebase sets the pace of the lamps. The mode machine samples its requests on every clock.

Each road gets a two-bit lamp code. The encoding is green = 00, yellow = 01 and red = 10. The code 11 is never produced.

Top module: `road_signal_ctrl`

## Requirements
- R1: When rst_n is low at a rising clock edge, the lights return to road A green with road B red (lamp_a=00, lamp_b=10) and the parade flag is cleared.
- R2: From A green on a step cycle, the lamps stay A green while sense_a=1. When sense_a=0 they go to A yellow with B red (lamp_a=01, lamp_b=10).
- R3: From A yellow, the next step cycle always moves to A red with B green (lamp_a=10, lamp_b=00), whatever the sensors show.
- R4: From B green on a step cycle, the lamps stay B green while sense_b=1 or the parade flag is set. Only when both are 0 do they go to B yellow (lamp_a=10, lamp_b=01).
- R5: From B yellow, the next step cycle always returns to A green with B red, whatever the sensors show.
- R6: On a cycle with step_en=0 the lamps do not change, whatever the sensors or requests do.
- R7: parade_req=1 sets the parade flag at the next clock edge, and release_req=1 clears it. If both are high in the same cycle, release wins. Requests take effect even while step_en=0.
- R8: With both requests low, the parade flag keeps its value.
- R9: At no time are both roads off red. Only the codes 00, 01 and 10 appear on either lamp output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both machines |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_a | input | 1 | Vehicle present on road A |
| sense_b | input | 1 | Vehicle present on road B |
| parade_req | input | 1 | Request to enter parade hold |
| release_req | input | 1 | Request to leave parade hold |
| step_en | input | 1 | Lets the lights machine advance this cycle |
| lamp_a | output | 2 | Road A lamp: 00 green, 01 yellow, 10 red |
| lamp_b | output | 2 | Road B lamp: 00 green, 01 yellow, 10 red |

## Verification
The parade flag never appears at a port. Its only visible effect is that road B stays green while its sensor is low. The bench therefore sets or clears the flag with short request pulses while step_en is low and the lamps are frozen. It then steps the lights into B green and holds sense_b low for several steps, so the lamp outputs show the flag's value. The same approach covers a simultaneous parade and release pulse, and a reset that lands while the flag is set.

// File: rtl/sig_pkg.sv
// Shared types for the two-road signal controller.
// Assumes a two-bit lamp code on each road.
package sig_pkg;
    localparam int LAMP_W = 2;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_t;

    typedef enum logic [1:0] {
        PH_A_GO   = 2'd0,
        PH_A_WARN = 2'd1,
        PH_B_GO   = 2'd2,
        PH_B_WARN = 2'd3
    } phase_t;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_PARADE = 1'b1
    } mode_t;
endpackage

// File: rtl/parade_mode_fsm.sv
// Mode machine: keeps the parade flag. Sampled every clock.
// Release has priority over parade. Assumes synchronous active-low reset.
module parade_mode_fsm
    import sig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic parade_req,
    input  logic release_req,
    output logic mode_on
);
    mode_t mode_q, mode_d;

    // Next mode: release wins, then parade, else hold.
    always_comb begin
        if (release_req)     mode_d = MODE_NORMAL;
        else if (parade_req) mode_d = MODE_PARADE;
        else                 mode_d = mode_q;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    assign mode_on = (mode_q == MODE_PARADE);
endmodule

// File: rtl/lights_phase_fsm.sv
// Lights machine: four phases, advances only when step_en is high.
// Assumes mode_on comes from a registered source.
module lights_phase_fsm
    import sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    input  logic   sense_a,
    input  logic   sense_b,
    input  logic   mode_on,
    output phase_t phase
);
    phase_t phase_q, phase_d;

    // Next-phase logic for one step.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_A_GO:   if (!sense_a) phase_d = PH_A_WARN;
            PH_A_WARN: phase_d = PH_B_GO;
            PH_B_GO:   if (!sense_b && !mode_on) phase_d = PH_B_WARN;
            PH_B_WARN: phase_d = PH_A_GO;
            default:   phase_d = PH_A_GO;
        endcase
    end

    // Phase register, gated by the step enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= PH_A_GO;
        else if (step_en) phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/lamp_decode.sv
// Lamp decoder for one road: green in its go phase, yellow in its
// warn phase, red otherwise. ON_B selects which road it serves.
module lamp_decode
    import sig_pkg::*;
#(
    parameter bit ON_B = 1'b0
) (
    input  phase_t            phase,
    output logic [LAMP_W-1:0] lamp
);
    localparam phase_t GO_PH   = ON_B ? PH_B_GO   : PH_A_GO;
    localparam phase_t WARN_PH = ON_B ? PH_B_WARN : PH_A_WARN;

    // Map phase to lamp code.
    always_comb begin
        if (phase == GO_PH)        lamp = LAMP_GO;
        else if (phase == WARN_PH) lamp = LAMP_WARN;
        else                       lamp = LAMP_STOP;
    end
endmodule

// File: rtl/road_signal_ctrl.sv
// Top: factored signal controller, mode machine feeding lights machine,
// lamp codes decoded per road. Assumes one clock and synchronous reset.
module road_signal_ctrl
    import sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sense_a,
    input  logic              sense_b,
    input  logic              parade_req,
    input  logic              release_req,
    input  logic              step_en,
    output logic [LAMP_W-1:0] lamp_a,
    output logic [LAMP_W-1:0] lamp_b
);
    logic   mode_on;
    phase_t phase;
    logic [LAMP_W-1:0] lamp_vec [2];

    parade_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n),
        .parade_req(parade_req), .release_req(release_req),
        .mode_on(mode_on)
    );

    lights_phase_fsm u_lights (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .sense_a(sense_a), .sense_b(sense_b), .mode_on(mode_on),
        .phase(phase)
    );

    for (genvar r = 0; r < 2; r++) begin : g_road
        lamp_decode #(.ON_B(r == 1)) u_dec (
            .phase(phase), .lamp(lamp_vec[r])
        );
    end

    assign lamp_a = lamp_vec[0];
    assign lamp_b = lamp_vec[1];
endmodule

// File: rtl/road_signal_ctrl_chk.sv
// Checker for road_signal_ctrl, attached by bind.
module road_signal_ctrl_chk
    import sig_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sense_a,
    input logic              sense_b,
    input logic              parade_req,
    input logic              release_req,
    input logic              step_en,
    input logic              mode_on,
    input logic [LAMP_W-1:0] lamp_a,
    input logic [LAMP_W-1:0] lamp_b
);
    assert_a_leaves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && lamp_a == LAMP_GO && !sense_a) |=> (lamp_a == LAMP_WARN && lamp_b == LAMP_STOP));

    assert_warn_to_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && lamp_a == LAMP_WARN) |=> (lamp_b == LAMP_GO && lamp_a == LAMP_STOP));

    assert_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && lamp_b == LAMP_GO && (sense_b || mode_on)) |=> (lamp_b == LAMP_GO));

    assert_b_to_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && lamp_b == LAMP_WARN) |=> (lamp_a == LAMP_GO && lamp_b == LAMP_STOP));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en) |=> ($stable(lamp_a) && $stable(lamp_b)));

    assert_release_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> !mode_on);

    assert_parade_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (parade_req && !release_req) |=> mode_on);

    assert_mode_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!parade_req && !release_req) |=> $stable(mode_on));

    // R9: one road red at all times, legal codes only
    always @(negedge clk) begin
        if (rst_n) begin
            assert_one_open_R9: assert (lamp_a == LAMP_STOP || lamp_b == LAMP_STOP);
            assert_codes_R9: assert (lamp_a != 2'b11 && lamp_b != 2'b11);
        end
    end
endmodule

bind road_signal_ctrl road_signal_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
    .parade_req(parade_req), .release_req(release_req), .step_en(step_en),
    .mode_on(mode_on), .lamp_a(lamp_a), .lamp_b(lamp_b)
);

// File: tb/road_signal_ctrl_tb.sv
`timescale 1ns/1ps
module road_signal_ctrl_tb;
    localparam logic [1:0] GRN = 2'b00, YEL = 2'b01, RED = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sense_a = 1'b0, sense_b = 1'b0;
    logic parade_req = 1'b0, release_req = 1'b0, step_en = 1'b0;
    logic [1:0] lamp_a, lamp_b;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    road_signal_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
        .parade_req(parade_req), .release_req(release_req), .step_en(step_en),
        .lamp_a(lamp_a), .lamp_b(lamp_b)
    );

    task automatic check(input logic [1:0] ea, input logic [1:0] eb, input string tag);
        total++;
        if (lamp_a !== ea || lamp_b !== eb) begin
            bad++;
            $display("FAIL %s: lamp_a=%b lamp_b=%b expected %b %b", tag, lamp_a, lamp_b, ea, eb);
        end
        total++;
        if (lamp_a !== RED && lamp_b !== RED) begin
            bad++;
            $display("FAIL R9: lamp_a=%b lamp_b=%b expected one red", lamp_a, lamp_b);
        end
    endtask

    // One clock with step_en high; sample at the following falling edge.
    task automatic step();
        step_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic p, input logic r);
        parade_req = p; release_req = r;
        @(negedge clk);
        parade_req = 1'b0; release_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        sense_a = 1; sense_b = 1;
        do_reset();
        check(GRN, RED, "R1 reset state");
    endtask

    task automatic t_hold_a();
        sense_a = 1; step();
        check(GRN, RED, "R2 A green held");
        sense_a = 0; sense_b = 1; idle(4);
        check(GRN, RED, "R6 no step, no change");
        sense_a = 1;
    endtask

    task automatic t_cycle();
        sense_a = 0; step();
        check(YEL, RED, "R2 A to yellow");
        sense_a = 1; sense_b = 0; idle(3);
        check(YEL, RED, "R6 yellow frozen");
        step();
        check(RED, GRN, "R3 yellow to B green");
        sense_b = 1; step();
        check(RED, GRN, "R4 B held by sensor");
        sense_b = 0; step();
        check(RED, YEL, "R4 B to yellow");
        sense_a = 0; sense_b = 1; step();
        check(GRN, RED, "R5 back to A green");
    endtask

    task automatic t_parade();
        sense_a = 1; sense_b = 0;
        pulse(1, 0);
        idle(3);
        check(GRN, RED, "R6 request alone moves no lamp");
        sense_a = 0; step(); step();
        check(RED, GRN, "R3 entered B green");
        step(); step(); step();
        check(RED, GRN, "R7 R8 parade keeps B green");
        pulse(1, 1);
        step();
        check(RED, YEL, "R7 release wins over parade");
        step();
        check(GRN, RED, "R5 return after parade");
    endtask

    task automatic t_release();
        sense_a = 1; sense_b = 0;
        pulse(1, 0); idle(2); pulse(0, 1);
        sense_a = 0; step(); step();
        check(RED, GRN, "R3 B green before release test");
        step();
        check(RED, YEL, "R7 released flag lets B go");
        step();
    endtask

    task automatic t_reset_clears();
        sense_a = 1; sense_b = 0;
        pulse(1, 0);
        do_reset();
        check(GRN, RED, "R1 reset during parade");
        sense_a = 0; step(); step();
        step();
        check(RED, YEL, "R1 reset cleared parade flag");
    endtask

    initial begin
        t_reset();
        t_hold_a();
        t_cycle();
        t_parade();
        t_release();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule